// File: doc/BRIEF.md
# Extended Stack Address Controller

This block owns the stack pointers of an 8-bit microcontroller core and turns push and pop requests into accesses on a single synchronous memory port. It holds an 8-bit stack pointer and a separate extension register. With the stack-mode bit clear, the stack sits in the 256-byte internal RAM and only the 8-bit pointer forms the address. With the bit set, the address grows to 10 bits: the two low bits of the extension register select one of four 256-byte banks in the internal extended RAM. Only the first 1 KB of that RAM can hold stack data.

A push pre-increments the pointer and writes at the new location. A pop reads at the current location and then post-decrements. In extended mode the extension register moves only when the 8-bit pointer wraps. Its upper six bits never change during stack operations. Both registers can also be loaded directly from the core's register-write path. The memory arrays and the instruction sequencing sit outside this block.

Top module: `stk_ctrl`

## Requirements
- R1: After reset the stack pointer reads 0x07, the extension register reads 0xFC, and `mem_en`, `pop_valid` and `conflict_err` are 0.
- R2: A push raises `mem_en` and `mem_we` in the same cycle. It drives `push_data` on `mem_wdata` at the incremented pointer value. After the clock edge the stack pointer holds that incremented value, wrapping 0xFF to 0x00.
- R3: With `ext_stack_en` at 0, accesses select internal RAM (`mem_sel_ext` = 0). Bits 9:8 of `mem_addr` are 0 and bits 7:0 carry the pointer. The extension register is not changed by stack operations, including a pointer wrap.
- R4: With `ext_stack_en` at 1, accesses select extended RAM (`mem_sel_ext` = 1). `mem_addr` is the two low bits of the extension register times 256, plus the 8-bit pointer.
- R5: In extended mode, a push that wraps the pointer to 0x00 increments the two low bits of the extension register (3 wraps to 0). The upper six bits are kept. The write of that push already uses the incremented bank.
- R6: A pop drives `mem_en` = 1 and `mem_we` = 0 at the current address, and the pointer decrements after the edge. One cycle later `pop_valid` is 1 and `pop_data` returns the memory's read data.
- R7: In extended mode, a pop that takes the pointer from 0x00 to 0xFF decrements the two low bits of the extension register (0 wraps to 3). The upper six bits are kept. The read uses the bank from before the decrement.
- R8: A write strobe for either register loads it after the edge. The strobe overrides any stack-operation update of that register in the same cycle, while the memory access of that operation still takes place.
- R9: A push and a pop in the same cycle perform the push only. `pop_valid` stays 0 in the next cycle and `conflict_err` is 1 for exactly that one cycle.
- R10: Data popped equals the data pushed last at the same location, in both modes and across bank boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_stack_en | input | 1 | Stack-mode bit: 1 selects the 10-bit stack in extended RAM |
| push_req | input | 1 | Push request |
| pop_req | input | 1 | Pop request |
| push_data | input | 8 | Byte to push |
| sp_wr_en | input | 1 | Load strobe for the stack pointer |
| sp_wr_data | input | 8 | Value loaded into the stack pointer |
| esp_wr_en | input | 1 | Load strobe for the extension register |
| esp_wr_data | input | 8 | Value loaded into the extension register |
| mem_rdata | input | 8 | Read data from the selected memory, one cycle after the request |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_sel_ext | output | 1 | 0 selects internal RAM, 1 selects extended RAM |
| mem_addr | output | 10 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| pop_valid | output | 1 | Pop data valid this cycle |
| pop_data | output | 8 | Popped byte |
| conflict_err | output | 1 | One-cycle flag after a simultaneous push and pop |
| stk_ptr | output | 8 | Current stack pointer |
| ext_ptr | output | 8 | Current extension register |

## Verification
The assertions on pointer steps assume no register-write strobe hits the same register in the checked cycle, so they are gated on those strobes. They also assume the memory behind the port returns read data exactly one cycle after a read strobe. The bench keeps to this by acting as that memory itself, with a one-cycle registered read.

Directed sequences drive the pointer across 0xFF/0x00 in both directions and in both modes. They also wrap the extension bank 3 to 0 and back, issue conflicting requests, and collide register writes with stack operations. Pseudo-random traffic then follows. Mode changes fall only between operations, so every pop has a well-defined bank.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } stk_op_e;

endpackage

// File: rtl/stk_op_arb.sv
module stk_op_arb
    import stk_pkg::*;
(
    input  logic    push_req,
    input  logic    pop_req,
    output stk_op_e op,
    output logic    clash
);

    always_comb begin
        clash = push_req && pop_req;
        if (push_req) begin
            op = OP_PUSH;
        end else if (pop_req) begin
            op = OP_POP;
        end else begin
            op = OP_IDLE;
        end
    end

endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen
    import stk_pkg::*;
#(
    parameter int SP_W  = 8,
    parameter int EXT_W = 2,
    parameter int ESP_W = 8,
    localparam int ADDR_W = SP_W + EXT_W
) (
    input  stk_op_e           op,
    input  logic              ext_mode,
    input  logic [SP_W-1:0]   sp_cur,
    input  logic [ESP_W-1:0]  esp_cur,
    output logic [SP_W-1:0]   sp_nx,
    output logic [ESP_W-1:0]  esp_nx,
    output logic [ADDR_W-1:0] addr,
    output logic              access
);

    logic [SP_W-1:0]  sp_inc;
    logic [SP_W-1:0]  sp_dec;
    logic [SP_W-1:0]  acc_sp;
    logic [EXT_W-1:0] bank;
    logic [EXT_W-1:0] bank_up;
    logic [EXT_W-1:0] bank_dn;

    always_comb begin
        sp_inc  = sp_cur + 1'b1;
        sp_dec  = sp_cur - 1'b1;
        bank_up = esp_cur[EXT_W-1:0] + 1'b1;
        bank_dn = esp_cur[EXT_W-1:0] - 1'b1;
        sp_nx   = sp_cur;
        esp_nx  = esp_cur;
        acc_sp  = sp_cur;
        access  = 1'b0;
        case (op)
            OP_PUSH: begin
                access = 1'b1;
                sp_nx  = sp_inc;
                acc_sp = sp_inc;
                if (ext_mode && (sp_inc == '0)) begin
                    esp_nx = {esp_cur[ESP_W-1:EXT_W], bank_up};
                end
            end
            OP_POP: begin
                access = 1'b1;
                sp_nx  = sp_dec;
                acc_sp = sp_cur;
                if (ext_mode && (sp_dec == '1)) begin
                    esp_nx = {esp_cur[ESP_W-1:EXT_W], bank_dn};
                end
            end
            default: ;
        endcase
        // push writes into the bank already advanced; pop reads the old bank
        bank = (op == OP_PUSH) ? esp_nx[EXT_W-1:0] : esp_cur[EXT_W-1:0];
        addr = ext_mode ? {bank, acc_sp} : {{EXT_W{1'b0}}, acc_sp};
    end

endmodule

// File: rtl/stk_ptr_regs.sv
module stk_ptr_regs #(
    parameter int              SP_W      = 8,
    parameter int              ESP_W     = 8,
    parameter logic [SP_W-1:0] SP_RST    = 8'h07,
    parameter logic [ESP_W-1:0] ESP_RST  = 8'hFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SP_W-1:0]  sp_nx,
    input  logic [ESP_W-1:0] esp_nx,
    input  logic             sp_wr_en,
    input  logic [SP_W-1:0]  sp_wr_data,
    input  logic             esp_wr_en,
    input  logic [ESP_W-1:0] esp_wr_data,
    output logic [SP_W-1:0]  sp_q,
    output logic [ESP_W-1:0] esp_q
);

    typedef struct packed {
        logic [SP_W-1:0]  sp;
        logic [ESP_W-1:0] esp;
    } ptr_t;

    ptr_t ptr_d;
    ptr_t ptr_q;

    always_comb begin
        ptr_d.sp  = sp_wr_en  ? sp_wr_data  : sp_nx;
        ptr_d.esp = esp_wr_en ? esp_wr_data : esp_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q.sp  <= SP_RST;
            ptr_q.esp <= ESP_RST;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign sp_q  = ptr_q.sp;
    assign esp_q = ptr_q.esp;

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SP_W   = 8,
    parameter int EXT_W  = 2,
    parameter int ESP_W  = 8,
    localparam int ADDR_W = SP_W + EXT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_stack_en,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              sp_wr_en,
    input  logic [SP_W-1:0]   sp_wr_data,
    input  logic              esp_wr_en,
    input  logic [ESP_W-1:0]  esp_wr_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic              mem_sel_ext,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pop_data,
    output logic              conflict_err,
    output logic [SP_W-1:0]   stk_ptr,
    output logic [ESP_W-1:0]  ext_ptr
);

    stk_op_e          op;
    logic             clash;
    logic [SP_W-1:0]  sp_nx;
    logic [ESP_W-1:0] esp_nx;
    logic             access;

    typedef struct packed {
        logic rd_pend;
        logic err;
    } stat_t;

    stat_t stat_d;
    stat_t stat_q;

    stk_op_arb u_arb (
        .push_req (push_req),
        .pop_req  (pop_req),
        .op       (op),
        .clash    (clash)
    );

    stk_addr_gen #(
        .SP_W  (SP_W),
        .EXT_W (EXT_W),
        .ESP_W (ESP_W)
    ) u_addr (
        .op       (op),
        .ext_mode (ext_stack_en),
        .sp_cur   (stk_ptr),
        .esp_cur  (ext_ptr),
        .sp_nx    (sp_nx),
        .esp_nx   (esp_nx),
        .addr     (mem_addr),
        .access   (access)
    );

    stk_ptr_regs #(
        .SP_W  (SP_W),
        .ESP_W (ESP_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sp_nx       (sp_nx),
        .esp_nx      (esp_nx),
        .sp_wr_en    (sp_wr_en),
        .sp_wr_data  (sp_wr_data),
        .esp_wr_en   (esp_wr_en),
        .esp_wr_data (esp_wr_data),
        .sp_q        (stk_ptr),
        .esp_q       (ext_ptr)
    );

    always_comb begin
        mem_en         = access;
        mem_we         = (op == OP_PUSH);
        mem_sel_ext    = ext_stack_en;
        mem_wdata      = push_data;
        stat_d.rd_pend = (op == OP_POP);
        stat_d.err     = clash;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign pop_valid    = stat_q.rd_pend;
    assign pop_data     = mem_rdata;
    assign conflict_err = stat_q.err;

    p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && !sp_wr_en |=> stk_ptr == SP_W'($past(stk_ptr) + 1'b1));

    p_we_only_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> push_req && mem_en);

    p_classic_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_stack_en && !esp_wr_en |=> ext_ptr == $past(ext_ptr));

    p_classic_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en && !ext_stack_en |-> mem_addr[ADDR_W-1:SP_W] == '0);

    p_upper_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !esp_wr_en |=> ext_ptr[ESP_W-1:EXT_W] == $past(ext_ptr[ESP_W-1:EXT_W]));

    p_pop_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && !push_req && !sp_wr_en |=> stk_ptr == SP_W'($past(stk_ptr) - 1'b1));

    p_pop_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && !push_req |=> pop_valid);

    p_sp_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wr_en |=> stk_ptr == $past(sp_wr_data));

    p_conflict_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && pop_req |=> conflict_err && !pop_valid);

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_req && pop_req) |=> !conflict_err);

endmodule

// File: tb/stk_ctrl_tb.sv
module stk_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_stack_en = 1'b0;
    logic       push_req = 1'b0;
    logic       pop_req = 1'b0;
    logic [7:0] push_data = '0;
    logic       sp_wr_en = 1'b0;
    logic [7:0] sp_wr_data = '0;
    logic       esp_wr_en = 1'b0;
    logic [7:0] esp_wr_data = '0;
    logic [7:0] mem_rdata = '0;
    logic       mem_en;
    logic       mem_we;
    logic       mem_sel_ext;
    logic [9:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       pop_valid;
    logic [7:0] pop_data;
    logic       conflict_err;
    logic [7:0] stk_ptr;
    logic [7:0] ext_ptr;

    int checks = 0;
    int errors = 0;

    // memory environment behind the port
    logic [7:0] int_ram [256];
    logic [7:0] ext_ram [1024];
    // reference model state
    int         m_sp;
    int         m_esp;
    logic [7:0] r_int [256];
    logic [7:0] r_ext [1024];

    always #5 clk = ~clk;

    stk_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ext_stack_en(ext_stack_en),
        .push_req(push_req), .pop_req(pop_req), .push_data(push_data),
        .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
        .esp_wr_en(esp_wr_en), .esp_wr_data(esp_wr_data),
        .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_we(mem_we),
        .mem_sel_ext(mem_sel_ext), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .pop_valid(pop_valid), .pop_data(pop_data), .conflict_err(conflict_err),
        .stk_ptr(stk_ptr), .ext_ptr(ext_ptr)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                if (mem_sel_ext) ext_ram[mem_addr] <= mem_wdata;
                else int_ram[mem_addr[7:0]] <= mem_wdata;
            end else begin
                mem_rdata <= mem_sel_ext ? ext_ram[mem_addr] : int_ram[mem_addr[7:0]];
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit ps, input bit pp, input logic [7:0] d,
                        input bit mode, input bit spw, input logic [7:0] spv,
                        input bit espw, input logic [7:0] espv);
        int  nsp;
        int  nesp;
        int  addr;
        bit  do_pop;
        logic [7:0] exp_pop;
        @(negedge clk);
        ext_stack_en = mode; push_req = ps; pop_req = pp; push_data = d;
        sp_wr_en = spw; sp_wr_data = spv; esp_wr_en = espw; esp_wr_data = espv;
        #1;
        do_pop = pp && !ps;
        nsp = m_sp; nesp = m_esp; exp_pop = '0; addr = 0;
        if (ps) begin
            nsp = (m_sp + 1) & 255;
            if (mode && nsp == 0) nesp = (m_esp & 8'hFC) | ((m_esp + 1) & 3);
            addr = mode ? (nesp & 3) * 256 + nsp : nsp;
            chk("R2 mem_en", mem_en, 1);
            chk("R2 mem_we", mem_we, 1);
            chk("R2 wdata", mem_wdata, d);
        end else if (do_pop) begin
            addr = mode ? (m_esp & 3) * 256 + m_sp : m_sp;
            exp_pop = mode ? r_ext[addr] : r_int[addr];
            nsp = (m_sp - 1) & 255;
            if (mode && nsp == 255) nesp = (m_esp & 8'hFC) | ((m_esp - 1) & 3);
            chk("R6 mem_en", mem_en, 1);
            chk("R6 mem_we", mem_we, 0);
        end else begin
            chk("R1 idle mem_en", mem_en, 0);
        end
        if (ps || do_pop) begin
            chk(mode ? "R4 addr" : "R3 addr", mem_addr, addr);
            chk(mode ? "R4 sel" : "R3 sel", mem_sel_ext, mode);
        end
        if (ps) begin
            if (mode) r_ext[addr] = d;
            else r_int[addr] = d;
        end
        if (spw) nsp = spv;
        if (espw) nesp = espv;
        m_sp = nsp; m_esp = nesp;
        @(posedge clk);
        #1;
        chk("R8 sp", stk_ptr, m_sp);
        chk("R5 R7 esp", ext_ptr, m_esp);
        chk("R6 pop_valid", pop_valid, do_pop);
        chk("R9 conflict_err", conflict_err, ps && pp);
        if (do_pop) chk("R10 pop_data", pop_data, exp_pop);
    endtask

    task automatic idle(input bit mode);
        step(0, 0, 8'h00, mode, 0, 8'h00, 0, 8'h00);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < 256; i++) begin int_ram[i] = '0; r_int[i] = '0; end
        for (int i = 0; i < 1024; i++) begin ext_ram[i] = '0; r_ext[i] = '0; end
        m_sp = 8'h07; m_esp = 8'hFC;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 sp", stk_ptr, 8'h07);
        chk("R1 esp", ext_ptr, 8'hFC);
        chk("R1 pop_valid", pop_valid, 0);
        chk("R1 conflict_err", conflict_err, 0);
        chk("R1 mem_en", mem_en, 0);

        // R2 R3 classic pushes and pops, wrap at 0xFF without touching ext_ptr
        step(1, 0, 8'hA1, 0, 0, 0, 0, 0);
        step(1, 0, 8'hA2, 0, 0, 0, 0, 0);
        step(0, 1, 8'h00, 0, 0, 0, 0, 0);
        step(0, 1, 8'h00, 0, 0, 0, 0, 0);
        step(0, 0, 8'h00, 0, 1, 8'hFE, 0, 0);
        step(1, 0, 8'hB1, 0, 0, 0, 0, 0);
        step(1, 0, 8'hB2, 0, 0, 0, 0, 0);
        step(1, 0, 8'hB3, 0, 0, 0, 0, 0);
        step(0, 1, 8'h00, 0, 0, 0, 0, 0);
        step(0, 1, 8'h00, 0, 0, 0, 0, 0);
        step(0, 1, 8'h00, 0, 0, 0, 0, 0);

        // R4 R5 R7 extended mode across a bank boundary, then bank wrap 3->0
        step(0, 0, 8'h00, 1, 1, 8'hFE, 1, 8'h51);
        step(1, 0, 8'hC1, 1, 0, 0, 0, 0);
        step(1, 0, 8'hC2, 1, 0, 0, 0, 0);
        step(1, 0, 8'hC3, 1, 0, 0, 0, 0);
        step(0, 1, 8'h00, 1, 0, 0, 0, 0);
        step(0, 1, 8'h00, 1, 0, 0, 0, 0);
        step(0, 1, 8'h00, 1, 0, 0, 0, 0);
        step(0, 0, 8'h00, 1, 1, 8'hFF, 1, 8'hAB);
        step(1, 0, 8'hD1, 1, 0, 0, 0, 0);
        step(0, 1, 8'h00, 1, 0, 0, 0, 0);
        step(0, 0, 8'h00, 1, 1, 8'h00, 1, 8'h7C);
        step(0, 1, 8'h00, 1, 0, 0, 0, 0);

        // R9 conflict, R8 load colliding with stack ops
        step(1, 1, 8'hE1, 1, 0, 0, 0, 0);
        idle(1);
        step(1, 0, 8'hE2, 1, 1, 8'h40, 0, 0);
        step(0, 1, 8'h00, 0, 0, 0, 1, 8'h12);
        idle(0);

        // pseudo-random traffic
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            bit ps;
            bit pp;
            bit md;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ps = lfsr[0] && lfsr[3];
            pp = lfsr[1] && !lfsr[3] || (lfsr[2:0] == 3'b111);
            md = (n / 50) % 2 == 1;
            step(ps, pp, lfsr[15:8], md, lfsr[9:4] == 6'd0, lfsr[7:0],
                 lfsr[11:6] == 6'd5, lfsr[15:8]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule